// File: doc/BRIEF.md
# Walking-Ring Stepped Sine Generator

This block produces the digital drive for a stepped-sine synthesiser built on a twisted (Johnson) ring counter. An external weighted resistor summer and a low-pass filter turn the ring's taps into a sine wave. Those parts sit outside this block.

A programmable divider sets the step rate from the system clock. Each divider tick advances the ring by one step, and one full walk of the ring is one output cycle. Three arrangements are available:
- **Single:** an 8-stage ring with 16 steps per cycle.
- **Quadrature:** the same 16-step ring, plus a second phase a quarter cycle ahead.
- **Three-phase:** a 12-stage ring with 24 steps per cycle, and three phases spaced a third of a cycle apart.

One stage of each ring is left untapped. As a result, two steps per cycle leave the driven pattern unchanged; these are the dwell steps.

A one-clock strobe marks each return of the ring to the all-zero state. The divide setting and the mode are taken up only at a cycle start or while the block is disabled. A changed setting therefore never breaks a cycle in progress.

Top module: `wring_sine_gen`

## Requirements
- R1: While reset is high and in the first clock after it, `phase_a`, `phase_b`, `phase_c` and `cyc_start` are all zero. Reset selects single mode and a divide factor of 256.
- R2: While `en` is high, the ring advances once every D clocks. D is `div_set` for values 1 to 255, and D is 256 when `div_set` is 0. The first step comes D clocks after `en` rises.
- R3: Single mode (`mode_sel` = 00) has 16 steps per cycle, counted from the all-zero state. `phase_a[i]` (i = 0..6) is 1 on steps i+1 to i+8 of each cycle. The untapped eighth stage makes steps 8 and 16 dwell steps, which leave `phase_a` unchanged.
- R4: Quadrature mode (`mode_sel` = 01) drives `phase_a` as in R3. `phase_b[6:0]` carries the same pattern 4 steps ahead: at step t it equals `phase_a` at step t+4.
- R5: Three-phase mode (`mode_sel` = 10) has 24 steps per cycle. `phase_a[i]` (i = 0..10) is 1 on steps i+1 to i+12. `phase_b` equals that pattern 8 steps behind, and `phase_c` equals it 16 steps behind.
- R6: `mode_sel` = 11 behaves as single mode. Outputs that a mode does not use read zero:
  - `phase_a[10:7]` in the 16-step modes;
  - `phase_b` in single mode;
  - `phase_c` outside three-phase mode.
- R7: The divide setting and the mode are captured only on a clock where `en` is low, or on the step that begins a new cycle. Changes at other times do not take effect.
- R8: `cyc_start` is high for exactly one clock, the clock right after the step that puts the ring into the all-zero state.
- R9: While `en` is low, the ring state and the phase outputs hold. Divider progress is discarded, so stepping resumes D clocks after `en` returns.
- R10: The ring only ever holds a legal pattern for the current length: at most one 0/1 boundary, and no ones above the active length. A ring found in any other pattern goes to all zeros on its next step, and that step raises `cyc_start`. An example is an 8-stage value 0xF0 seen as a 12-stage ring after a mode change made while paused. While such a pattern is held in three-phase mode, all three phases read 0x0F0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low pauses the ring |
| div_set | input | 8 | Step divide factor (0 means 256) |
| mode_sel | input | 2 | 00 single, 01 quadrature, 10 three-phase, 11 single |
| phase_a | output | 11 | First phase tap pattern |
| phase_b | output | 11 | Second phase tap pattern |
| phase_c | output | 11 | Third phase tap pattern |
| cyc_start | output | 1 | One-clock strobe after the ring returns to all zeros |

## Verification
The assertions watch the following on every clock:
- ring legality;
- a change of exactly one stage per step;
- no ring change without a divider tick;
- the divider count staying within its limit and clearing while paused;
- the strobe being a single clock that coincides with the all-zero ring;
- the captured settings changing only at a legal capture point;
- the zeroing of unused outputs.

The bench scenarios show the things a single-cycle property cannot:
- the exact step patterns and phase offsets in each mode;
- the divide ratios, including divide by 256;
- deferral of a setting changed mid-cycle until the next cycle start;
- the hold while paused;
- recovery from an illegal pattern created by a mode switch while paused.

// File: rtl/wring_pkg.sv
package wring_pkg;

    localparam int RING_SHORT = 8;
    localparam int RING_LONG  = 12;
    localparam int RING_MAX   = (RING_LONG > RING_SHORT) ? RING_LONG : RING_SHORT;
    localparam int TAP_W      = RING_MAX - 1;
    localparam int DIV_W      = 8;

    typedef logic [RING_MAX-1:0] ring_t;
    typedef logic [TAP_W-1:0]    taps_t;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_QUAD   = 2'b01,
        MODE_TRI    = 2'b10
    } wr_mode_e;

    typedef struct packed {
        wr_mode_e           mode;
        logic [DIV_W-1:0]   div;
    } wr_cfg_t;

    function automatic wr_mode_e decode_mode(input logic [1:0] sel);
        wr_mode_e m;
        case (sel)
            2'b01:   m = MODE_QUAD;
            2'b10:   m = MODE_TRI;
            default: m = MODE_SINGLE;
        endcase
        return m;
    endfunction

    function automatic int ring_len(input wr_mode_e m);
        return (m == MODE_TRI) ? RING_LONG : RING_SHORT;
    endfunction

    // A legal twisted-ring pattern has no ones above the active length
    // and at most one boundary between adjacent active stages.
    function automatic logic ring_legal(input ring_t r, input int n);
        int   edges;
        logic clean;
        edges = 0;
        clean = 1'b1;
        for (int i = 0; i < RING_MAX; i++) begin
            if (i >= n && r[i]) clean = 1'b0;
            if (i < n - 1 && i < RING_MAX - 1) begin
                if (r[i] != r[i+1]) edges = edges + 1;
            end
        end
        return clean && (edges <= 1);
    endfunction

    // Shift in the inverse of the last active stage.
    function automatic ring_t ring_advance(input ring_t r, input int n);
        ring_t nx;
        nx = '0;
        nx[0] = ~r[n-1];
        for (int i = 1; i < RING_MAX; i++) begin
            if (i < n) nx[i] = r[i-1];
        end
        return nx;
    endfunction

endpackage

// File: rtl/wring_stepdiv.sv
module wring_stepdiv
    import wring_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic         tick
);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    pause_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);

endmodule

// File: rtl/wring_ring.sv
module wring_ring
    import wring_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  wr_mode_e mode,
    output ring_t    ring,
    output logic     wrap,
    output logic     strobe
);

    int    n;
    logic  legal;
    ring_t nxt;

    always_comb begin
        n     = ring_len(mode);
        legal = ring_legal(ring, n);
        nxt   = legal ? ring_advance(ring, n) : '0;
    end

    assign wrap = tick && (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ring   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= wrap;
            if (tick) ring <= nxt;
        end
    end

    // R9
    ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ring));

    // R10
    ring_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && legal) |=> ring_legal(ring, ring_len(mode)));

    // R3
    one_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && legal) |=> ($countones(ring ^ $past(ring)) == 1));

    // R8
    strobe_zero_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (ring == '0));

    // R8
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/wring_taps.sv
module wring_taps
    import wring_pkg::*;
(
    input  ring_t    ring,
    input  wr_mode_e mode,
    output taps_t    pa,
    output taps_t    pb,
    output taps_t    pc
);

    localparam int QLEAD = RING_SHORT / 2;
    localparam int TOFF  = (2 * RING_LONG) / 3;

    taps_t short_a, quad_b, tri_a, tri_b, tri_c;

    for (genvar j = 0; j < TAP_W; j++) begin : g_tap
        assign tri_a[j] = ring[j];

        if (j + TOFF < RING_LONG) begin : g_lag_in
            assign tri_b[j] = ring[j+TOFF];
        end else begin : g_lag_wrap
            assign tri_b[j] = ~ring[j+TOFF-RING_LONG];
        end

        if (j >= TOFF) begin : g_lead_in
            assign tri_c[j] = ring[j-TOFF];
        end else begin : g_lead_wrap
            assign tri_c[j] = ~ring[j-TOFF+RING_LONG];
        end

        if (j < RING_SHORT - 1) begin : g_short
            assign short_a[j] = ring[j];
            if (j >= QLEAD) begin : g_q_in
                assign quad_b[j] = ring[j-QLEAD];
            end else begin : g_q_wrap
                assign quad_b[j] = ~ring[j-QLEAD+RING_SHORT];
            end
        end else begin : g_short_off
            assign short_a[j] = 1'b0;
            assign quad_b[j]  = 1'b0;
        end
    end

    always_comb begin
        case (mode)
            MODE_TRI: begin
                pa = tri_a;
                pb = tri_b;
                pc = tri_c;
            end
            MODE_QUAD: begin
                pa = short_a;
                pb = quad_b;
                pc = '0;
            end
            default: begin
                pa = short_a;
                pb = '0;
                pc = '0;
            end
        endcase
    end

endmodule

// File: rtl/wring_sine_gen.sv
module wring_sine_gen
    import wring_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div_set,
    input  logic [1:0]    mode_sel,
    output logic [TAP_W-1:0] phase_a,
    output logic [TAP_W-1:0] phase_b,
    output logic [TAP_W-1:0] phase_c,
    output logic          cyc_start
);

    wr_cfg_t cfg;
    logic    cfg_load;
    logic    tick;
    logic    wrap;
    ring_t   ring;
    logic [DW-1:0] lim;

    assign cfg_load = !en || wrap;
    assign lim      = cfg.div - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{mode: MODE_SINGLE, div: '0};
        end else if (cfg_load) begin
            cfg <= '{mode: decode_mode(mode_sel), div: div_set};
        end
    end

    wring_stepdiv #(.W(DW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .lim  (lim),
        .tick (tick)
    );

    wring_ring u_ring (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .mode   (cfg.mode),
        .ring   (ring),
        .wrap   (wrap),
        .strobe (cyc_start)
    );

    wring_taps u_taps (
        .ring (ring),
        .mode (cfg.mode),
        .pa   (phase_a),
        .pb   (phase_b),
        .pc   (phase_c)
    );

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(cfg));

    // R6
    unused_c_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode != MODE_TRI) |-> (phase_c == '0));

    // R6
    unused_b_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_SINGLE) |-> (phase_b == '0));

    // R6
    upper_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode != MODE_TRI) |-> (phase_a[TAP_W-1:RING_SHORT-1] == '0));

endmodule

// File: tb/test_wring_sine_gen.sv
module test_wring_sine_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  div_set = 8'd0;
    logic [1:0]  mode_sel = 2'b00;
    logic [10:0] phase_a, phase_b, phase_c;
    logic        cyc_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    int mcnt = 0, mt = 0, md = 256, mm = 0;
    bit ms = 1'b0, ill = 1'b0;

    always #4 clk = ~clk;

    wring_sine_gen i_wring_sine_gen (
        .clk(clk), .rst(rst), .en(en), .div_set(div_set), .mode_sel(mode_sel),
        .phase_a(phase_a), .phase_b(phase_b), .phase_c(phase_c),
        .cyc_start(cyc_start)
    );

    function automatic bit bv(int t, int i, int n);
        int p = 2 * n;
        int u = (((t - 1 - i) % p) + p) % p;
        return (u < n);
    endfunction

    function automatic int dec_mode(logic [1:0] s);
        return (s == 2'b10) ? 2 : (s == 2'b01) ? 1 : 0;
    endfunction

    function automatic int period();
        return (mm == 2) ? 24 : 16;
    endfunction

    task automatic model();
        if (rst) begin
            mcnt = 0; mt = 0; md = 256; mm = 0; ms = 0; ill = 0;
        end else if (!en) begin
            mcnt = 0; ms = 0;
            md = (div_set == 0) ? 256 : int'(div_set);
            mm = dec_mode(mode_sel);
        end else if (mcnt == md - 1) begin
            mcnt = 0;
            if (ill) begin
                mt = 0; ill = 0;
            end else begin
                mt = (mt + 1) % period();
            end
            ms = (mt == 0);
            if (mt == 0) begin
                md = (div_set == 0) ? 256 : int'(div_set);
                mm = dec_mode(mode_sel);
            end
        end else begin
            mcnt = mcnt + 1;
            ms = 0;
        end
    endtask

    task automatic compare(string tag);
        logic [10:0] ea, eb, ec;
        ea = '0; eb = '0; ec = '0;
        if (ill) begin
            ea = 11'h0F0; eb = 11'h0F0; ec = 11'h0F0;
        end else if (mm == 2) begin
            for (int j = 0; j < 11; j++) begin
                ea[j] = bv(mt, j, 12);
                eb[j] = bv(mt - 8, j, 12);
                ec[j] = bv(mt + 8, j, 12);
            end
        end else begin
            for (int j = 0; j < 7; j++) begin
                ea[j] = bv(mt, j, 8);
                if (mm == 1) eb[j] = bv(mt + 4, j, 8);
            end
        end
        checks++;
        if (phase_a !== ea || phase_b !== eb || phase_c !== ec || cyc_start !== ms) begin
            errors++;
            $display("FAIL %s: a=%h b=%h c=%h s=%b expected a=%h b=%h c=%h s=%b",
                     tag, phase_a, phase_b, phase_c, cyc_start, ea, eb, ec, ms);
        end
    endtask

    task automatic step_clk(string tag);
        @(posedge clk);
        model();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) step_clk(tag);
    endtask

    task automatic run_to(int t, string tag);
        for (int k = 0; k < 20000 && mt != t; k++) step_clk(tag);
    endtask

    initial begin
        // R1: reset state
        run(3, "R1 reset");
        rst = 1'b0;
        step_clk("R1 after reset");

        // R2 R3: divide by 1, single mode, full cycles with dwell steps
        div_set = 8'd1; mode_sel = 2'b00;
        step_clk("R7 load while idle");
        en = 1'b1;
        run(40, "R2 R3 single div1");

        // R7: a mid-cycle divide change waits for the cycle start
        run_to(5, "R3 single");
        div_set = 8'd3;
        run(120, "R7 R2 deferred div3");

        // R7: a mid-cycle mode change waits for the cycle start
        run_to(7, "R3 single div3");
        mode_sel = 2'b10;
        run(200, "R7 R5 deferred tri div3");

        // R5: three-phase at divide 1 and divide 5
        en = 1'b0; div_set = 8'd1;
        step_clk("R9 pause tri");
        en = 1'b1;
        run(60, "R5 tri div1");
        en = 1'b0; div_set = 8'd5;
        step_clk("R9 pause tri");
        en = 1'b1;
        run(260, "R5 tri div5");

        // R9: pause holds the outputs
        en = 1'b0;
        run(20, "R9 hold");

        // R4: quadrature, entered while paused mid-cycle back at 16 steps
        run_to(0, "R9 hold");
        mode_sel = 2'b01; div_set = 8'd2;
        step_clk("R4 load quad");
        en = 1'b1;
        run(80, "R4 quad div2");

        // R6: code 11 acts as single
        en = 1'b0; mode_sel = 2'b11; div_set = 8'd1;
        run_to(0, "R6 wait");
        step_clk("R6 load");
        en = 1'b1;
        run(40, "R6 code11 single");

        // R2: divide setting 0 is 256
        run_to(0, "R2 wait");
        en = 1'b0; div_set = 8'd0; mode_sel = 2'b00;
        step_clk("R2 load 256");
        en = 1'b1;
        run(16 * 256 + 20, "R2 div256");

        // R10: illegal pattern after a mode switch while paused at step 12
        en = 1'b0; div_set = 8'd1; mode_sel = 2'b00;
        step_clk("R10 prep");
        en = 1'b1;
        run_to(12, "R10 prep");
        en = 1'b0; mode_sel = 2'b10; div_set = 8'd2;
        ill = 1'b1;
        step_clk("R10 illegal held");
        run(3, "R10 illegal held");
        en = 1'b1;
        run(60, "R10 recovery R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule